// File: doc/BRIEF.md
# Multi-Step LFSR Random Word Generator

This block turns a 4-bit linear feedback shift register into a source of pseudo-random 4-bit words. The register uses XNOR feedback, which makes the all-zeros pattern a legal state and the all-ones pattern the single lock-up value that must never be entered. Because a shift register only yields one fresh bit per clock, a word request advances the register four times before the word is published. That way successive words are not simply the previous word doubled, with or without one added.

A one-cycle request starts an advance sequence, and a valid strobe marks the finished word. A seed input can place the register at any legal value, and a lock-up seed is mapped to zero. A single-step mode advances once per request so the raw state sequence can be observed. A pacing prescaler, chosen by parameter, lets shifts happen only on a slow tick, so the output can be watched by a person. With the default setting, every clock is a tick.

Top module: `lfsr_word_gen`

## Requirements
- R1: After synchronous reset `word_o` is 4'h0, `valid_o` is 0 and the register holds 4'h0, so the first single-step word is 4'h1.
- R2: The register never holds 4'hF, whatever the stimulus.
- R3: One advance maps state s to {s[2:0], ~(s[3] ^ s[0])}: the register shifts toward bit 3 and the XNOR of bits 3 and 0 enters at bit 0. From 4'h0 it visits 15 distinct states before repeating.
- R4: With `single_i`=0, a request sampled at clock edge k gives four advances. At edge k+4 (default pacing) `valid_o` rises and `word_o` equals the state after those four advances. `valid_o` stays 0 in between.
- R5: `valid_o` is high for exactly one cycle per completed word.
- R6: A request that arrives while a sequence is running is ignored: the word still reflects exactly four advances, and no extra word follows.
- R7: When `load_i` is sampled high, the register takes `seed_i`. A seed of 4'hF is replaced by 4'h0. Any running sequence is cancelled without a valid strobe, and `word_o` keeps its value. Load wins over a simultaneous request.
- R8: With `single_i`=1, a request sampled at edge k gives one advance, and the new state appears on `word_o` with `valid_o` high at edge k+1.
- R9: With PACE_DIV=D>1, advances happen only on a tick every D cycles. A four-step word therefore completes between 3D+1 and 4D cycles after its request and holds the same value as with no pacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Word request strobe |
| single_i | input | 1 | 1: one advance per request; 0: four advances |
| load_i | input | 1 | Seed load strobe |
| seed_i | input | 4 | Seed value |
| word_o | output | 4 | Latest random word, registered |
| valid_o | output | 1 | One-cycle strobe marking a new word |

## Verification
Each result has a fixed latency. A four-step word is due at the fourth rising edge after its request edge, and a single-step word at the first. A seed load shows its effect at the next edge, seen through the word from the following single step. The bench drives and samples on falling edges, checks `valid_o` low on every intermediate cycle and high on exactly the due cycle, and compares `word_o` with a model state advanced once per shift. For the paced instance, the cycle count from request to strobe is measured and checked against the window that the tick spacing allows.

// File: rtl/lfsr_word_pkg.sv
package lfsr_word_pkg;
  localparam int unsigned WORD_W = 4;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/lfsr_pace_tick.sv
module lfsr_pace_tick #(
  parameter int unsigned PACE_DIV = 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (PACE_DIV <= 1) begin : g_free
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(PACE_DIV);
      localparam logic [CW-1:0] LAST = CW'(PACE_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);

      assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/lfsr_xnor_core.sv
module lfsr_xnor_core #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned TAP_A = 3,
  parameter int unsigned TAP_B = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  output logic [WIDTH-1:0] state_o,
  output logic [WIDTH-1:0] next_o
);
  localparam logic [WIDTH-1:0] LOCKUP = '1;

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] seed_fixed;
  logic             fb;

  assign fb         = ~(state_q[TAP_A] ^ state_q[TAP_B]);
  assign next_o     = {state_q[WIDTH-2:0], fb};
  assign seed_fixed = (seed_i == LOCKUP) ? '0 : seed_i;
  assign state_o    = state_q;

  always_ff @(posedge clk) begin
    if (rst)         state_q <= '0;
    else if (load_i) state_q <= seed_fixed;
    else if (step_i) state_q <= next_o;
  end

  assert_no_lockup_R2: assert property (@(posedge clk) disable iff (rst)
    state_q != LOCKUP);

  assert_shift_path_R3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0]));

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !load_i) |=> $stable(state_q));

  assert_seed_fix_R7: assert property (@(posedge clk) disable iff (rst)
    (load_i && seed_i == LOCKUP) |=> state_q == '0);
endmodule

// File: rtl/lfsr_step_seq.sv
module lfsr_step_seq
  import lfsr_word_pkg::*;
#(
  parameter int unsigned STEPS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic single_i,
  input  logic load_i,
  input  logic tick_i,
  output logic step_o,
  output logic done_o,
  output logic valid_o
);
  localparam int unsigned CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] FULL = CW'(STEPS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  seq_state_e     st_q;
  logic [CW-1:0]  left_q;
  logic           valid_q;

  assign step_o  = (st_q == SEQ_RUN) && tick_i && !load_i;
  assign done_o  = step_o && (left_q == ONE);
  assign valid_o = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SEQ_IDLE;
      left_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= done_o;
      if (load_i) begin
        st_q   <= SEQ_IDLE;
        left_q <= '0;
      end else if (st_q == SEQ_IDLE) begin
        if (req_i) begin
          st_q   <= SEQ_RUN;
          left_q <= single_i ? ONE : FULL;
        end
      end else if (step_o) begin
        left_q <= left_q - 1'b1;
        if (left_q == ONE) st_q <= SEQ_IDLE;
      end
    end
  end

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    left_q <= FULL);

  assert_idle_on_valid_R6: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> st_q == SEQ_IDLE);

  assert_load_cancel_R7: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (st_q == SEQ_IDLE) && !valid_q);
endmodule

// File: rtl/lfsr_word_gen.sv
module lfsr_word_gen
  import lfsr_word_pkg::*;
#(
  parameter int unsigned WIDTH    = WORD_W,
  parameter int unsigned TAP_A    = 3,
  parameter int unsigned TAP_B    = 0,
  parameter int unsigned PACE_DIV = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             single_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  output logic [WIDTH-1:0] word_o,
  output logic             valid_o
);
  logic             tick;
  logic             step;
  logic             done;
  logic [WIDTH-1:0] state;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] word_q;

  lfsr_pace_tick #(.PACE_DIV(PACE_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  lfsr_step_seq #(.STEPS(WIDTH)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req_i),
    .single_i (single_i),
    .load_i   (load_i),
    .tick_i   (tick),
    .step_o   (step),
    .done_o   (done),
    .valid_o  (valid_o)
  );

  lfsr_xnor_core #(.WIDTH(WIDTH), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_core (
    .clk     (clk),
    .rst     (rst),
    .step_i  (step),
    .load_i  (load_i),
    .seed_i  (seed_i),
    .state_o (state),
    .next_o  (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)       word_q <= '0;
    else if (done) word_q <= nxt;
  end

  assign word_o = word_q;

  assert_word_matches_R4: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> word_o == state);

  assert_word_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(word_q));
endmodule

// File: tb/lfsr_word_gen_test.sv
`timescale 1ns/1ps
module lfsr_word_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0, single = 1'b0, load = 1'b0;
  logic [3:0] seed = 4'h0;
  logic [3:0] word;
  logic       valid;
  logic       p_req = 1'b0;
  logic [3:0] p_word;
  logic       p_valid;
  logic [3:0] m;
  int         n_chk = 0, n_bad = 0;

  localparam int PD = 3;

  always #4 clk = ~clk;

  lfsr_word_gen uut (
    .clk(clk), .rst(rst), .req_i(req), .single_i(single), .load_i(load),
    .seed_i(seed), .word_o(word), .valid_o(valid));

  lfsr_word_gen #(.PACE_DIV(PD)) uut_paced (
    .clk(clk), .rst(rst), .req_i(p_req), .single_i(1'b0), .load_i(1'b0),
    .seed_i(4'h0), .word_o(p_word), .valid_o(p_valid));

  function automatic logic [3:0] adv(input logic [3:0] s);
    return {s[2:0], ~(s[3] ^ s[0])};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // request a word; inject=1 raises req again while busy (R6)
  task automatic get_word(input bit one, input bit inject);
    int steps = one ? 1 : 4;
    @(negedge clk); req = 1'b1; single = one;
    @(posedge clk);
    @(negedge clk); req = 1'b0;
    for (int i = 1; i <= steps; i++) begin
      if (inject && i == 1 && steps > 1) req = 1'b1;
      @(posedge clk);
      @(negedge clk); req = 1'b0;
      m = adv(m);
      if (i < steps) check(valid == 1'b0, "R4 valid early", int'(valid), 0);
      else begin
        check(valid == 1'b1, one ? "R8 valid due" : "R4 valid due", int'(valid), 1);
        check(word == m, one ? "R8 word" : (inject ? "R6 word" : "R4 word"), int'(word), int'(m));
        check(word != 4'hF, "R2 lockup", int'(word), 0);
      end
    end
    @(posedge clk); @(negedge clk);
    check(valid == 1'b0, inject ? "R6 extra word" : "R5 pulse width", int'(valid), 0);
  endtask

  task automatic seed_load(input logic [3:0] s);
    logic [3:0] w0;
    @(negedge clk); w0 = word; load = 1'b1; seed = s;
    @(posedge clk);
    @(negedge clk); load = 1'b0;
    m = (s == 4'hF) ? 4'h0 : s;
    check(valid == 1'b0, "R7 no valid", int'(valid), 0);
    check(word == w0, "R7 word hold", int'(word), int'(w0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : main
    logic [15:0] seen;
    logic [3:0]  first;
    int unsigned r;
    int          lat;
    r = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check(word == 4'h0, "R1 reset word", int'(word), 0);
    check(valid == 1'b0, "R1 reset valid", int'(valid), 0);
    m = 4'h0;
    get_word(1'b1, 1'b0);
    check(word == 4'h1, "R1 first step", int'(word), 1);

    // R3: period of 15 from zero, never F
    seed_load(4'h0);
    seen = '0;
    for (int i = 0; i < 15; i++) begin
      get_word(1'b1, 1'b0);
      if (i == 0) first = word;
      check(!seen[word], "R3 distinct", int'(word), 0);
      seen[word] = 1'b1;
    end
    check(seen == 16'h7FFF, "R3 coverage", int'(seen), 32'h7FFF);
    get_word(1'b1, 1'b0);
    check(word == first, "R3 period 15", int'(word), int'(first));

    // R4 / R6
    get_word(1'b0, 1'b0);
    get_word(1'b0, 1'b1);

    // R7: lock-up seed mapped to zero, seen through one step
    seed_load(4'hF);
    get_word(1'b1, 1'b0);
    check(word == 4'h1, "R7 F->0 seed", int'(word), 1);
    seed_load(4'h9);
    get_word(1'b1, 1'b0);

    // R7: load cancels a running sequence
    @(negedge clk); req = 1'b1; single = 1'b0;
    @(posedge clk); @(negedge clk); req = 1'b0;
    @(posedge clk); @(negedge clk); m = adv(m);
    seed_load(4'h5);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); @(negedge clk);
      check(valid == 1'b0, "R7 cancel", int'(valid), 0);
    end
    get_word(1'b1, 1'b0);

    // R7: load beats a simultaneous request
    @(negedge clk); req = 1'b1; load = 1'b1; seed = 4'h3;
    @(posedge clk); @(negedge clk); req = 1'b0; load = 1'b0; m = 4'h3;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); @(negedge clk);
      check(valid == 1'b0, "R7 load priority", int'(valid), 0);
    end
    get_word(1'b1, 1'b0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      r = $urandom % 4;
      case (r)
        0: seed_load(4'($urandom));
        1: get_word(1'b1, 1'b0);
        2: get_word(1'b0, 1'b0);
        default: get_word(1'b0, 1'b1);
      endcase
    end

    // R9: paced instance
    @(negedge clk); p_req = 1'b1;
    @(posedge clk); @(negedge clk); p_req = 1'b0;
    lat = 0;
    while (!p_valid && lat < 100) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    check(lat >= 3*PD + 1 && lat <= 4*PD, "R9 latency", lat, 4*PD);
    check(p_word == adv(adv(adv(adv(4'h0)))), "R9 word", int'(p_word),
          int'(adv(adv(adv(adv(4'h0))))));
    summary();
  end
endmodule